// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a 32-bit physical address. It does this by reading two entries from a translation table held in memory. A directory base register points at a first-level directory of 4096 word entries. Virtual address bits 31:20 select one of these entries. A valid directory entry points at a second-level table of 256 word entries, and virtual bits 19:12 select one of those. The selected leaf entry supplies the 4 KiB page frame and a 4-bit permission-domain index. The low 12 virtual bits pass through as the offset within the page.

The walker accepts one address at a time over a valid/ready port. It issues its word reads on a request port that has its own handshake, and it takes each read's data from a response strobe. When the walk ends it presents one of three results and holds it until the requester takes it: a translation, a first-level fault or a second-level fault. Each fault level has its own register that captures the faulting virtual address. When translation is disabled, or when bypass is requested, the address passes through unchanged and no memory read is made.

Top module: `pt_walker`

## Requirements
- R1: During and after reset, `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0, and both fault address registers read 0.
- R2: The first read of a walk is the word at `base + va[31:20]*4`, where `base` is the directory base register.
- R3: The second read of a walk is the word at `{L1[31:10], 10'b0} + va[19:12]*4`, where `L1` is the first-level entry that was read.
- R4: A first-level entry is valid only when its bits 1:0 equal 01, and its bits 9:2 are ignored. Any other value ends the walk with `rsp_fault_l1`=1, `rsp_fault_l2`=0, `rsp_paddr`=0 and `rsp_perm`=0, and no second read is made.
- R5: A leaf entry is valid only when its bit 1 is set. Otherwise the walk ends with `rsp_fault_l2`=1, `rsp_fault_l1`=0, `rsp_paddr`=0 and `rsp_perm`=0.
- R6: A valid leaf gives `rsp_paddr = {leaf[31:12], va[11:0]}` and `rsp_perm = leaf[7:4]`. Leaf bits 11:8, 3:2 and 0 have no effect on the result.
- R7: A first-level fault loads `va` into `flt_l1_addr`, and a second-level fault loads `va` into `flt_l2_addr`. Each register changes only on its own level's fault.
- R8: While `en` is 0 or `bypass` is 1, a request returns `rsp_paddr = va` with `rsp_perm`=0 and no fault, and no memory read is made.
- R9: Only one request is in flight at a time: `req_ready` stays low from acceptance until the result is taken. A result that has not been accepted stays valid and unchanged. A memory request that has not been accepted keeps the same address.
- R10: `base_wr` loads `base_wdata` into the directory base register only while `en` is 0. A write while `en` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Translation enable |
| bypass | input | 1 | Pass addresses through untranslated |
| base_wr | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 32 | Physical address of the first-level directory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_addr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_perm | output | 4 | Permission-domain index of the page |
| rsp_fault_l1 | output | 1 | First-level entry was invalid |
| rsp_fault_l2 | output | 1 | Second-level entry was invalid |
| flt_l1_addr | output | 32 | Last virtual address that faulted at the first level |
| flt_l2_addr | output | 32 | Last virtual address that faulted at the second level |
| mem_req_valid | output | 1 | Table word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table word read |

## Verification
The hardest cases to reach are those where stalls overlap a walk: a memory request waits for several cycles, and a finished result is held while the requester withholds `rsp_ready`. In those windows a walker that is only almost correct drops or changes an address. The bench's memory model drops `mem_req_ready` on a repeating pattern, and its requester drops `rsp_ready` on a different one, so the two stall types fall at different points across many walks. Every read address the walker issues is compared against a queue the bench computes from its own table image. A missing read, an extra read or a misplaced read is therefore reported, including a second read after a first-level fault and any read in pass-through.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW       = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8,
  parameter int PERM_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bypass,
  input  logic              base_wr,
  input  logic [AW-1:0]     base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [AW-1:0]     rsp_paddr,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              rsp_fault_l1,
  output logic              rsp_fault_l2,
  output logic [AW-1:0]     flt_l1_addr,
  output logic [AW-1:0]     flt_l2_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [AW-1:0]     mem_rsp_data
);
  localparam int OFF_W    = AW - L1_IDX_W - L2_IDX_W;
  localparam int TBL_LSB  = L2_IDX_W + 2;
  localparam int PERM_LSB = 4;

  typedef enum logic [2:0] {S_IDLE, S_L1A, S_L1D, S_L2A, S_L2D, S_DONE} st_t;

  st_t             st;
  logic [AW-1:0]   base_q, va_q, tbl_q, pa_q;
  logic [PERM_W-1:0] perm_q;
  logic            f1_q, f2_q;

  wire [AW-1:0] l1_off = AW'({va_q[AW-1 -: L1_IDX_W], 2'b00});
  wire [AW-1:0] l2_off = AW'({va_q[OFF_W +: L2_IDX_W], 2'b00});
  wire          l1_ok  = mem_rsp_data[1:0] == 2'b01;
  wire          l2_ok  = mem_rsp_data[1];

  assign req_ready     = st == S_IDLE;
  assign rsp_valid     = st == S_DONE;
  assign mem_req_valid = st == S_L1A || st == S_L2A;
  assign mem_req_addr  = (st == S_L1A) ? base_q + l1_off : tbl_q + l2_off;
  assign rsp_paddr     = pa_q;
  assign rsp_perm      = perm_q;
  assign rsp_fault_l1  = f1_q;
  assign rsp_fault_l2  = f2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      base_q      <= '0;
      va_q        <= '0;
      tbl_q       <= '0;
      pa_q        <= '0;
      perm_q      <= '0;
      f1_q        <= 1'b0;
      f2_q        <= 1'b0;
      flt_l1_addr <= '0;
      flt_l2_addr <= '0;
    end else begin
      if (base_wr && !en) base_q <= base_wdata;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_addr;
          if (!en || bypass) begin
            pa_q   <= req_addr;
            perm_q <= '0;
            f1_q   <= 1'b0;
            f2_q   <= 1'b0;
            st     <= S_DONE;
          end else begin
            st <= S_L1A;
          end
        end
        S_L1A: if (mem_req_ready) st <= S_L1D;
        S_L1D: if (mem_rsp_valid) begin
          if (l1_ok) begin
            tbl_q <= {mem_rsp_data[AW-1:TBL_LSB], TBL_LSB'(0)};
            st    <= S_L2A;
          end else begin
            pa_q        <= '0;
            perm_q      <= '0;
            f1_q        <= 1'b1;
            f2_q        <= 1'b0;
            flt_l1_addr <= va_q;
            st          <= S_DONE;
          end
        end
        S_L2A: if (mem_req_ready) st <= S_L2D;
        S_L2D: if (mem_rsp_valid) begin
          f1_q <= 1'b0;
          st   <= S_DONE;
          if (l2_ok) begin
            pa_q   <= {mem_rsp_data[AW-1:OFF_W], va_q[OFF_W-1:0]};
            perm_q <= mem_rsp_data[PERM_LSB +: PERM_W];
            f2_q   <= 1'b0;
          end else begin
            pa_q        <= '0;
            perm_q      <= '0;
            f2_q        <= 1'b1;
            flt_l2_addr <= va_q;
          end
        end
        S_DONE: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW     = 32,
  parameter int PERM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [AW-1:0]     rsp_paddr,
  input logic [PERM_W-1:0] rsp_perm,
  input logic              rsp_fault_l1,
  input logic              rsp_fault_l2,
  input logic [AW-1:0]     flt_l1_addr,
  input logic [AW-1:0]     flt_l2_addr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [AW-1:0]     mem_req_addr
);
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_perm)
      && $stable(rsp_fault_l1) && $stable(rsp_fault_l2));

  a_r9_hold_memreq: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  a_r4_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fault_l1 && rsp_fault_l2));

  a_r7_l1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_l1_addr) |-> rsp_valid && rsp_fault_l1);

  a_r7_l2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_l2_addr) |-> rsp_valid && rsp_fault_l2);

  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault_l1 || rsp_fault_l2) |-> rsp_paddr == '0 && rsp_perm == '0);
endmodule

bind pt_walker pt_walker_chk #(.AW(AW), .PERM_W(PERM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
  .rsp_fault_l1(rsp_fault_l1), .rsp_fault_l2(rsp_fault_l2),
  .flt_l1_addr(flt_l1_addr), .flt_l2_addr(flt_l2_addr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr));

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, bypass = 1'b0, base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_ready = 1'b0;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        req_ready, rsp_valid, rsp_fault_l1, rsp_fault_l2, mem_req_valid;
  logic [31:0] rsp_paddr, flt_l1_addr, flt_l2_addr, mem_req_addr;
  logic [3:0]  rsp_perm;

  int checks = 0, fails = 0;
  logic [31:0] mem [logic [31:0]];
  logic [37:0] exp_res_q [$];
  logic [31:0] exp_rd_q [$];
  logic [31:0] base_s = '0, exp_f1 = '0, exp_f2 = '0;
  int          cyc = 0;
  logic        hs_n = 1'b0;
  logic [31:0] data_n = '0;

  always #10 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .en(en), .bypass(bypass), .base_wr(base_wr),
    .base_wdata(base_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault_l1(rsp_fault_l1),
    .rsp_fault_l2(rsp_fault_l2), .flt_l1_addr(flt_l1_addr), .flt_l2_addr(flt_l2_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input string what, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // stall patterns
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 0;
    rsp_ready     <= (cyc % 5) != 1;
    mem_rsp_valid <= hs_n;
    mem_rsp_data  <= data_n;
  end

  // memory monitor: read addresses must match R2/R3/R4/R8 expectations
  always @(negedge clk) begin
    hs_n = 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      hs_n   = 1'b1;
      data_n = rd(mem_req_addr);
      if (exp_rd_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4/R8 unexpected read: actual %h expected none", mem_req_addr);
      end else begin
        chk("R2/R3", "read address", {6'h0, mem_req_addr}, {6'h0, exp_rd_q.pop_front()});
      end
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_res_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected result: actual %h expected none", rsp_paddr);
      end else begin
        logic [37:0] e;
        e = exp_res_q.pop_front();
        chk("R5/R6", "result", {rsp_fault_l2, rsp_fault_l1, rsp_perm, rsp_paddr}, e);
        if (e[36]) exp_f1 = req_hist_va;
        if (e[37]) exp_f2 = req_hist_va;
        chk("R7", "flt_l1_addr", {6'h0, flt_l1_addr}, {6'h0, exp_f1});
        chk("R7", "flt_l2_addr", {6'h0, flt_l2_addr}, {6'h0, exp_f2});
      end
    end
  end

  logic [31:0] req_hist_va = '0;

  task automatic issue(input logic [31:0] va);
    logic [31:0] a1, e1, a2, e2;
    @(negedge clk);
    while (!req_ready || exp_res_q.size() != 0) @(negedge clk);
    if (!en || bypass) begin
      exp_res_q.push_back({2'b00, 4'h0, va});
    end else begin
      a1 = base_s + {18'h0, va[31:20], 2'b00};
      exp_rd_q.push_back(a1);
      e1 = rd(a1);
      if (e1[1:0] != 2'b01) begin
        exp_res_q.push_back({2'b01, 4'h0, 32'h0});
      end else begin
        a2 = {e1[31:10], 10'h0} + {22'h0, va[19:12], 2'b00};
        exp_rd_q.push_back(a2);
        e2 = rd(a2);
        if (!e2[1]) exp_res_q.push_back({2'b10, 4'h0, 32'h0});
        else        exp_res_q.push_back({2'b00, e2[7:4], e2[31:12], va[11:0]});
      end
    end
    req_hist_va = va;
    req_valid = 1'b1;
    req_addr  = va;
    @(negedge clk);
    req_valid = 1'b0;
    // R9: busy until result taken
    chk("R9", "req_ready while busy", {37'h0, req_ready}, 38'h0);
  endtask

  task automatic drain();
    while (exp_res_q.size() != 0 || exp_rd_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  task automatic write_base(input logic [31:0] v);
    drain();
    base_wr = 1'b1; base_wdata = v;
    if (!en) base_s = v;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  initial begin
    // table image
    mem[32'h0001_0000 + 32'h123*4] = 32'h0040_0001;
    mem[32'h0040_0000 + 32'h45*4]  = 32'hABCD_E052;
    mem[32'h0040_0000 + 32'h46*4]  = 32'h1234_5F5F;
    mem[32'h0040_0000 + 32'h47*4]  = 32'hFFFF_FFFD;
    mem[32'h0001_0000 + 32'h200*4] = 32'h0050_03FD;
    mem[32'h0050_0000 + 32'hFF*4]  = 32'h7654_3072;
    mem[32'h0001_0000 + 32'h300*4] = 32'h0060_0003;
    mem[32'h0001_0000 + 32'h301*4] = 32'h0060_0002;
    mem[32'h0001_0000 + 32'hFFF*4] = 32'h0070_0001;
    mem[32'h0070_0000 + 32'hFF*4]  = 32'hFEDC_B0F2;
    mem[32'h0002_0000 + 32'h123*4] = 32'h0080_0001;
    mem[32'h0080_0000 + 32'h45*4]  = 32'h1111_10A2;

    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {req_ready, rsp_valid, mem_req_valid, 35'h0},
        {1'b1, 1'b0, 1'b0, 35'h0});
    chk("R1", "reset fault regs", {6'h0, flt_l1_addr | flt_l2_addr}, 38'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10/R8: disabled, load base, pass-through
    write_base(32'h0001_0000);
    issue(32'h1234_5678);   // R8 disabled pass-through
    drain();
    en = 1'b1;
    issue(32'h1234_5678);   // R2 R3 R6
    issue(32'h1234_6ABC);   // R6 reserved leaf bits ignored
    issue(32'h1234_7001);   // R5 bit1 clear leaf
    issue(32'h200F_F123);   // R4 reserved L1 bits ignored
    issue(32'h3000_0000);   // R4 low bits 11
    issue(32'h3010_0FFF);   // R4 low bits 10
    issue(32'h4000_0000);   // R4 zero entry
    issue(32'hFFFF_FFFF);   // R2 top index
    issue(32'h1234_8000);   // R5 absent leaf
    drain();
    bypass = 1'b1;
    issue(32'hDEAD_BEEF);   // R8 bypass
    drain();
    bypass = 1'b0;
    write_base(32'h0002_0000); // R10 ignored while enabled
    issue(32'h1234_5678);
    drain();
    en = 1'b0;
    write_base(32'h0002_0000); // R10 accepted while disabled
    en = 1'b1;
    issue(32'h1234_5678);
    drain();
    write_base(32'h0001_0000);
    en = 1'b0;
    write_base(32'h0001_0000);
    en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] va;
      va = {(i % 3 == 0) ? 12'h123 : (i % 3 == 1) ? 12'h200 : 12'h300,
            8'h44 + 8'(i % 5), 12'(i * 97)};
      issue(va);
    end
    drain();
    repeat (4) @(negedge clk);
    chk("R9", "idle after drain", {37'h0, req_ready}, 38'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule